// File: doc/BRIEF.md
# GPIO Bank Data and Direction Controller

This block manages one bank of general-purpose pins behind a small word-addressed register bus. Software picks, per pin, whether the block drives the pad or only listens to it, and it changes driven levels through two write-one masks: one raises the selected bits and one lowers them. Because of these masks, a single pin can change without a read-modify-write sequence. A register that loads all output bits at once is also provided.

Every pad input passes through a chain of synchronizer flops clocked by the bank clock. The input register always shows the synchronized pad level, including on pins that the block is driving, so software can read back what the pad actually carries. As a result of the synchronizer, a read taken right after an output change can still return the earlier level.

The register bus takes one access per cycle. A write is accepted on the clock edge where select and write are both high. Read data is combinational from the selected word.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every pin is an input: the direction word reads all ones, `pad_oe` is all zeros, and the output word and `pad_out` are all zeros.
- R2: A write to word 0 (direction) loads all bits. A 1 makes the pin an input and a 0 makes it an output, so `pad_oe` equals the inverse of the direction word from the clock edge that accepts the write.
- R3: A write to word 1 (output data) loads all output bits, and `pad_out` shows them from the accepting edge.
- R4: A write to word 2 (set mask) drives high every output bit written as 1 and leaves every bit written as 0 unchanged.
- R5: A write to word 3 (clear mask) drives low every output bit written as 1 and leaves every bit written as 0 unchanged.
- R6: Reads of word 2 and word 3 return the current output data word.
- R7: A read of word 4 (input data) returns the pad level for every pin, including driven pins. A pad change first appears after the second rising clock edge and is not visible after only one.
- R8: Writes to word 4 and to unused words 5 to 7 change neither direction nor output data. Reads of unused words return zero.
- R9: When `bus_sel` is low, `bus_wr` has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word index: 0 direction, 1 output, 2 set, 3 clear, 4 input |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected word |
| pad_in | input | 32 | Pad levels (asynchronous) |
| pad_out | output | 32 | Output level per pin |
| pad_oe | output | 32 | Output enable per pin, 1 = driven |

## Verification
If the direction or output state is wrong, the error shows on `pad_oe` or `pad_out` at the very edge that accepts the faulty write, and it stays there until the next write. A mask that reaches the wrong bits shows on the neighbouring pins that should have kept their level. If the synchronizer is too short or too long, the input word reads one cycle early or late. The bench therefore samples input reads exactly one and two edges after each pad change.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        REG_DIR  = 3'd0,
        REG_DOUT = 3'd1,
        REG_SET  = 3'd2,
        REG_CLR  = 3'd3,
        REG_PIN  = 3'd4
    } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stg[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.stg[i] = st_q.stg[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.stg[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_bank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_idx,
    input  logic [W-1:0]      wr_data,
    output logic [W-1:0]      dir_o,
    output logic [W-1:0]      dout_o
);
    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] dout;
    } bank_st_t;

    bank_st_t     st_d, st_q;
    logic [W-1:0] set_m, clr_m;

    always_comb begin
        st_d  = st_q;
        set_m = '0;
        clr_m = '0;
        if (wr_en) begin
            case (wr_idx)
                REG_DIR:  st_d.dir  = wr_data;
                REG_DOUT: st_d.dout = wr_data;
                REG_SET:  set_m     = wr_data;
                REG_CLR:  clr_m     = wr_data;
                default:  ;
            endcase
        end
        // set has priority when both masks touch one bit
        st_d.dout = (st_d.dout & ~clr_m) | set_m;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.dir  <= '1;
            st_q.dout <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dir_o  = st_q.dir;
    assign dout_o = st_q.dout;
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
    import gpio_bank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [REG_AW-1:0] rd_idx,
    input  logic [W-1:0]      dir_i,
    input  logic [W-1:0]      dout_i,
    input  logic [W-1:0]      pin_i,
    output logic [W-1:0]      rdata_o
);
    always_comb begin
        case (rd_idx)
            REG_DIR:           rdata_o = dir_i;
            REG_DOUT, REG_SET,
            REG_CLR:           rdata_o = dout_i;
            REG_PIN:           rdata_o = pin_i;
            default:           rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int N_PINS      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [N_PINS-1:0] bus_wdata,
    output logic [N_PINS-1:0] bus_rdata,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_oe
);
    logic [N_PINS-1:0] dir_w, dout_w, pin_w;
    logic              wr_en;

    assign wr_en = bus_sel & bus_wr;

    gpio_regfile #(.W(N_PINS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (bus_addr),
        .wr_data (bus_wdata),
        .dir_o   (dir_w),
        .dout_o  (dout_w)
    );

    gpio_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_in),
        .sync_o  (pin_w)
    );

    gpio_rd_mux #(.W(N_PINS)) u_rd (
        .rd_idx  (bus_addr),
        .dir_i   (dir_w),
        .dout_i  (dout_w),
        .pin_i   (pin_w),
        .rdata_o (bus_rdata)
    );

    assign pad_out = dout_w;
    assign pad_oe  = ~dir_w;
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk
    import gpio_bank_pkg::*;
#(
    parameter int N_PINS      = 32,
    parameter int SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [REG_AW-1:0] bus_addr,
    input logic [N_PINS-1:0] bus_wdata,
    input logic [N_PINS-1:0] bus_rdata,
    input logic [N_PINS-1:0] pad_in,
    input logic [N_PINS-1:0] pad_out,
    input logic [N_PINS-1:0] pad_oe
);
    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd0) |-> (pad_oe == '0 && pad_out == '0));

    p_dir_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == REG_DIR) |=> (pad_oe == ~$past(bus_wdata)));

    p_dout_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == REG_DOUT) |=> (pad_out == $past(bus_wdata)));

    p_set_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == REG_SET) |=>
        (pad_out == ($past(pad_out) | $past(bus_wdata))));

    p_clr_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == REG_CLR) |=>
        (pad_out == ($past(pad_out) & ~$past(bus_wdata))));

    p_no_touch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bus_sel && bus_wr) || bus_addr > REG_CLR) |=>
        ($stable(pad_out) && $stable(pad_oe)));

    p_sync_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (SYNC_STAGES == 2 && since_rst == 2'd3 && bus_sel && !bus_wr && bus_addr == REG_PIN)
        |-> (bus_rdata == $past(pad_in, 2)));
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.N_PINS(N_PINS), .SYNC_STAGES(SYNC_STAGES)) u_chk (.*);

// File: tb/gpio_bank_ctrl_bench.sv
module gpio_bank_ctrl_bench;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]   bus_addr = '0;
    logic [W-1:0] bus_wdata = '0, bus_rdata, pad_in = '0, pad_out, pad_oe;

    int n_run = 0, n_fail = 0;
    logic [W-1:0] exp_dir, exp_out;

    always #2 clk = ~clk;

    gpio_bank_ctrl u_gpio_bank_ctrl (.*);

    task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    function automatic logic [W-1:0] pat(input int k);
        return (32'h9E3779B9 * (k + 1)) ^ (32'h1 << (k % 32));
    endfunction

    initial begin
        #400000;
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] r;
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(3'd0, r); check(r, '1, "R1 dir");
        check(pad_oe, '0, "R1 pad_oe");
        check(pad_out, '0, "R1 pad_out");
        rd(3'd1, r); check(r, '0, "R1 dout");
        rst_n = 1'b1;
        exp_dir = '1; exp_out = '0;

        // R2 / R3 full-word loads over patterns
        for (int k = 0; k < 8; k++) begin
            exp_dir = pat(k);
            wr(3'd0, exp_dir);
            check(pad_oe, ~exp_dir, "R2 pad_oe");
            rd(3'd0, r); check(r, exp_dir, "R2 readback");
            exp_out = ~pat(k + 20);
            wr(3'd1, exp_out);
            check(pad_out, exp_out, "R3 pad_out");
        end

        // R4 / R5 walking masks, R6 readback through mask words
        exp_out = 32'hA5A5_0F0F;
        wr(3'd1, exp_out);
        for (int b = 0; b < W; b++) begin
            exp_out = exp_out | (32'h1 << b);
            wr(3'd2, 32'h1 << b);
            check(pad_out, exp_out, "R4 walking set");
            rd(3'd2, r); check(r, exp_out, "R6 set word read");
        end
        for (int b = 0; b < W; b += 3) begin
            exp_out = exp_out & ~(32'h1 << b);
            wr(3'd3, 32'h1 << b);
            check(pad_out, exp_out, "R5 walking clear");
            rd(3'd3, r); check(r, exp_out, "R6 clear word read");
        end
        for (int k = 0; k < 8; k++) begin
            exp_out = exp_out | pat(k + 40);
            wr(3'd2, pat(k + 40));
            check(pad_out, exp_out, "R4 multi-bit set");
            exp_out = exp_out & ~pat(k + 50);
            wr(3'd3, pat(k + 50));
            check(pad_out, exp_out, "R5 multi-bit clear");
        end
        wr(3'd2, '0); check(pad_out, exp_out, "R4 zero mask");
        wr(3'd3, '0); check(pad_out, exp_out, "R5 zero mask");

        // R8 ignored addresses, R9 write without select
        for (int a = 4; a < 8; a++) begin
            wr(a[2:0], ~exp_out);
            check(pad_out, exp_out, "R8 dout untouched");
            check(pad_oe, ~exp_dir, "R8 oe untouched");
            if (a > 4) begin rd(a[2:0], r); check(r, '0, "R8 unused read zero"); end
        end
        for (int a = 0; a < 4; a++) begin
            @(negedge clk);
            bus_sel = 1'b0; bus_wr = 1'b1; bus_addr = a[2:0]; bus_wdata = ~exp_out;
            @(negedge clk);
            bus_wr = 1'b0;
            #1;
            check(pad_out, exp_out, "R9 dout untouched");
            check(pad_oe, ~exp_dir, "R9 oe untouched");
        end

        // R7 synchronizer latency, with some pins driven
        wr(3'd0, 32'h0000_FFFF);
        for (int k = 0; k < 10; k++) begin
            logic [W-1:0] old_v, new_v;
            old_v = pad_in;
            new_v = pat(k + 70);
            @(negedge clk);
            pad_in = new_v;
            @(negedge clk);
            rd(3'd4, r); check(r, old_v, "R7 one edge old level");
            @(negedge clk);
            rd(3'd4, r); check(r, new_v, "R7 two edges new level");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule